// File: doc/BRIEF.md
# Asymmetric Registered Bus Transceiver

This block joins two 18-bit data ports, called A and B, and moves words between them in both directions at once. A word on A goes to B through a plain combinational buffer, so it appears on B in the same cycle. A word on B goes to A through clocked storage. A path-select input chooses between two B-to-A routes. One is a four-stage pipeline. The other is a single register.

All B-to-A storage is updated on the rising clock edge, and only while the active-low stall input is low. The single register and the first pipeline stage both load from B on every enabled edge. Because of this, changing the path select exposes whichever route is chosen at that moment, and nothing is flushed.

Each direction has its own active-high drive enable. There are no physical tri-state pins. Each side is modelled as an output word plus an output-enable flag. While a side is not driven, its word reads as zero.

A synchronous active-high reset clears all storage.

Top module: `regbus_xcvr`

## Requirements
- R1: While `drive_b` is high, `b_out` equals `a_in` in the same cycle, and `b_oe` is high.
- R2: While `drive_b` is low, `b_oe` is low and `b_out` is zero.
- R3: With `sel_deep` = 0 (single-register route), `a_out` equals the `b_in` value captured at the most recent enabled rising edge.
- R4: With `sel_deep` = 1 (four-stage route), `a_out` equals the `b_in` value captured four enabled rising edges earlier.
- R5: A rising edge with `stall` = 1 changes no storage. `a_out` stays stable if `sel_deep` and `drive_a` do not change, and held contents are kept across a change of `sel_deep`.
- R6: The single register and the first pipeline stage both load `b_in` on every enabled edge. Toggling `sel_deep` in mid-stream switches `a_out` between 1-edge and 4-edge history with no flush, and it takes effect in the same cycle.
- R7: While `drive_a` is low, `a_oe` is low and `a_out` is zero. Storage still updates, and its contents become visible once `drive_a` returns high.
- R8: A rising edge with `rst` = 1 clears all storage to zero, whatever the level of `stall`. Afterwards `a_out` is zero on both routes until new data is captured.
- R9: The two directions are independent. The enable, data and route of one direction have no effect on the other direction's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Word presented on port A |
| b_in | input | 18 | Word presented on port B |
| drive_b | input | 1 | Active-high enable for driving port B |
| drive_a | input | 1 | Active-high enable for driving port A |
| stall | input | 1 | Active-low clock enable: 1 holds all storage |
| sel_deep | input | 1 | Route select: 1 four-stage pipeline, 0 single register |
| b_out | output | 18 | Word driven toward port B (zero when not driven) |
| b_oe | output | 1 | Port B output-enable flag |
| a_out | output | 18 | Word driven toward port A (zero when not driven) |
| a_oe | output | 1 | Port A output-enable flag |

## Verification
The B-to-A route is exercised with several input patterns:
- A steady stream of random words on each route shows that the latency is one edge or four edges.
- Randomly placed stall cycles tell a stalled edge apart from an enabled one, since only enabled edges count.
- Toggling the route select every few cycles shows that both routes are filled at the same time and that nothing is flushed.

Further patterns target the enables and the reset:
- Disabling the A drive while data keeps streaming shows that storage runs on behind a gated output.
- Disabling one direction while the other stays active confirms that the two directions are independent.
- A reset issued during a stall proves that reset overrides the stall.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  // Route selection for the B-to-A direction
  typedef enum logic {
    ROUTE_SINGLE = 1'b0,
    ROUTE_DEEP   = 1'b1
  } route_t;

endpackage

// File: rtl/regbus_a2b_buf.sv
module regbus_a2b_buf #(
  parameter int WIDTH = 18
) (
  input  logic [WIDTH-1:0] din,
  input  logic             enable,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);

  // Pure combinational pass-through; zero while not driving
  always_comb begin
    oe   = enable;
    dout = enable ? din : '0;
  end

endmodule

// File: rtl/regbus_b2a_store.sv
module regbus_b2a_store #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] single_q,
  output logic [WIDTH-1:0] deep_q
);

  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] stage_q [DEPTH];

  // Single register route
  always_ff @(posedge clk) begin
    if (rst)
      single_q <= '0;
    else if (cap_en)
      single_q <= din;
  end

  // Shift pipeline route, one generated register per stage
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)
          stage_q[i] <= '0;
        else if (cap_en)
          stage_q[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)
          stage_q[i] <= '0;
        else if (cap_en)
          stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign deep_q = stage_q[LAST];

endmodule

// File: rtl/regbus_b2a_sel.sv
module regbus_b2a_sel
  import regbus_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic [WIDTH-1:0] single_q,
  input  logic [WIDTH-1:0] deep_q,
  input  logic             sel_deep,
  input  logic             enable,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);

  route_t route;

  always_comb begin
    route = route_t'(sel_deep);
    oe    = enable;
    if (!enable)
      dout = '0;
    else if (route == ROUTE_DEEP)
      dout = deep_q;
    else
      dout = single_q;
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             drive_b,
  input  logic             drive_a,
  input  logic             stall,
  input  logic             sel_deep,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe
);

  logic             cap_en;
  logic [WIDTH-1:0] single_q;
  logic [WIDTH-1:0] deep_q;

  assign cap_en = ~stall;

  regbus_a2b_buf #(.WIDTH(WIDTH)) u_a2b (
    .din    (a_in),
    .enable (drive_b),
    .dout   (b_out),
    .oe     (b_oe)
  );

  regbus_b2a_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .din      (b_in),
    .single_q (single_q),
    .deep_q   (deep_q)
  );

  regbus_b2a_sel #(.WIDTH(WIDTH)) u_sel (
    .single_q (single_q),
    .deep_q   (deep_q),
    .sel_deep (sel_deep),
    .enable   (drive_a),
    .dout     (a_out),
    .oe       (a_oe)
  );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             drive_b,
  input logic             drive_a,
  input logic             stall,
  input logic             sel_deep,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe
);

  // R1
  a2b_pass_chk: assert property (@(posedge clk) disable iff (rst)
    drive_b |-> (b_oe && b_out == a_in));

  // R2
  a2b_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_b |-> (!b_oe && b_out == '0));

  // R3
  short_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stall) && !sel_deep && drive_a) |-> (a_out == $past(b_in)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stall) && $stable(sel_deep) && $stable(drive_a)) |-> $stable(a_out));

  // R7
  b2a_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_a |-> (!a_oe && a_out == '0));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_out == '0));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .b_in     (b_in),
  .drive_b  (drive_b),
  .drive_a  (drive_a),
  .stall    (stall),
  .sel_deep (sel_deep),
  .b_out    (b_out),
  .b_oe     (b_oe),
  .a_out    (a_out),
  .a_oe     (a_oe)
);

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb;

  localparam int W = 18;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic         drive_b, drive_a, stall, sel_deep;
  logic [W-1:0] b_out, a_out;
  logic         b_oe, a_oe;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R8";
  bit done = 1'b0;

  logic [W-1:0] hist [$];

  always #4 clk = ~clk;

  regbus_xcvr #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .drive_b(drive_b), .drive_a(drive_a), .stall(stall), .sel_deep(sel_deep),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
  );

  // Reference: history of captured words, newest first
  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      for (int i = 0; i < D; i++) hist.push_back('0);
    end else if (!stall && hist.size() == D) begin
      hist.push_front(b_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done && hist.size() == D) begin
      logic [W-1:0] exp_a;
      logic [W-1:0] exp_b;
      exp_a = !drive_a ? '0 : (sel_deep ? hist[D-1] : hist[0]);
      exp_b = drive_b ? a_in : '0;
      check(drive_b ? "R1" : "R2", {b_oe, b_out}, {drive_b, exp_b});
      check(!drive_a ? "R7" : tag, {a_oe, a_out}, {drive_a, exp_a});
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      a_in = W'($urandom);
      b_in = W'($urandom);
    end
  endtask

  initial begin
    rst = 1'b1; a_in = '0; b_in = 18'h3ffff; drive_b = 1'b1; drive_a = 1'b1;
    stall = 1'b0; sel_deep = 1'b0;
    step(3);
    rst = 1'b0;
    // R8 reset state visible on both routes
    tag = "R8"; step(1);
    // R3 single-register route
    tag = "R3"; sel_deep = 1'b0; step(20);
    // R4 four-stage route
    tag = "R4"; sel_deep = 1'b1; step(20);
    // R5 random stalls, including route changes while stalled
    tag = "R5";
    for (int i = 0; i < 30; i++) begin
      stall = $urandom_range(0, 1) == 1;
      if (i % 7 == 0) sel_deep = ~sel_deep;
      step(1);
    end
    stall = 1'b0;
    // R6 toggle route mid-stream
    tag = "R6";
    for (int i = 0; i < 8; i++) begin
      sel_deep = ~sel_deep;
      step(3);
    end
    // R7 A side disabled while storage keeps loading
    drive_a = 1'b0; sel_deep = 1'b1; step(10);
    tag = "R7"; drive_a = 1'b1; step(2);
    // R9 one direction off, the other active
    tag = "R9"; drive_b = 1'b0; step(8);
    drive_b = 1'b1; drive_a = 1'b0; step(8);
    drive_a = 1'b1; step(4);
    // R8 reset during stall must still clear
    tag = "R8"; stall = 1'b1; rst = 1'b1; step(2);
    rst = 1'b0; sel_deep = 1'b0; step(2);
    sel_deep = 1'b1; step(1);
    stall = 1'b0; tag = "R4"; step(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule